// File: doc/BRIEF.md
# Programmable Countdown Timer with Second and Minute Interrupts

This block counts down an 8-bit value at one of four rates taken from a 32.768 kHz reference, and raises a timer flag each time the count runs out. The reference arrives as a one-cycle enable pulse `ref_tick_i` in the system clock domain, one pulse per reference period. A chain of four dividers turns it into four rates: 4096 Hz, 64 Hz, 1 Hz and one tick per minute. The same chain also marks second and minute boundaries. Those boundaries set a shared second/minute flag when their enables are on.

Software reaches three byte registers through a single-cycle write strobe and a combinational read port. These are a control/status byte, a timer control byte and the countdown value. A single interrupt output either follows the enabled flags as a level, or emits one-cycle pulses, one for each event.

The divider ratios are parameters. A test can shrink them so that a minute boundary arrives after a few dozen clocks.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control/status byte (address 0x1) reads 0x00, the timer control byte (0xE) reads 0x03, the countdown value (0xF) reads 0x00, and `irq_o` is low.
- R2: Register map. Control/status (0x1) holds: bit 7 minute enable, bit 6 second enable, bit 5 second/minute flag, bit 4 pulse mode, bit 2 timer flag, bit 0 timer interrupt enable. Bits 3 and 1 of that byte read 0. Timer control (0xE) holds: bit 7 run enable, bits 1:0 source select, other bits read 0. Any other address reads 0x00 and ignores writes.
- R3: While the run enable is 0, the countdown value holds. A write to 0xF loads both the reload value and the counter, and a read of 0xF returns the live counter.
- R4: The source select gives a tick period of DIV_FAST reference ticks for 00, DIV_FAST*DIV_MID for 01, that times DIV_SEC for 10, and that times DIV_MIN for 11. With the defaults these are 8, 512, 32768 and 1966080 reference ticks.
- R5: With a reload value N of 1 or more and the run enable set, an expiry occurs every N source ticks. A tick at a count of 1 reloads N; any other tick decrements.
- R6: A reload value of 0 keeps the timer stopped, with no expiry.
- R7: An expiry sets the timer flag. Writing 0 to the timer flag clears it, writing 1 leaves it unchanged, and a set in the same cycle as a clear wins.
- R8: When pulse mode is 0, `irq_o` = (timer flag AND timer interrupt enable) OR (second/minute flag AND (second enable OR minute enable)).
- R9: When pulse mode is 1, `irq_o` is a one-cycle pulse in the cycle after each expiry that has the timer interrupt enable set, and after each enabled second or minute event.
- R10: The second/minute flag is set on each second boundary while the second enable is 1, and on each minute boundary while the minute enable is 1. Only a written 0 clears it, and it never sets while both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle pulse per 32.768 kHz reference period |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address for writes and reads |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt, level or pulse per pulse mode |

## Verification
The minute boundary and the slowest timer source are the hardest events to reach from the ports. With the default ratios they lie almost two million reference ticks away. The bench therefore sets the four divider ratios to 2, 2, 2 and 3 and holds `ref_tick_i` high, so the four periods become 2, 4, 8 and 24 clocks. It then measures the spacing of interrupt pulses in pulse mode for each source and for the second and minute events, and compares it with N times the source period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 4;

  typedef enum logic [1:0] {
    SRC_FAST = 2'b00,
    SRC_MID  = 2'b01,
    SRC_SEC  = 2'b10,
    SRC_MIN  = 2'b11
  } src_e;

  localparam logic [AW-1:0] ADDR_CTRL = 4'h1;
  localparam logic [AW-1:0] ADDR_TCTL = 4'hE;
  localparam logic [AW-1:0] ADDR_TVAL = 4'hF;

  // control/status bit positions
  localparam int unsigned B_MIN_EN = 7;
  localparam int unsigned B_SEC_EN = 6;
  localparam int unsigned B_MSF    = 5;
  localparam int unsigned B_PULSE  = 4;
  localparam int unsigned B_TF     = 2;
  localparam int unsigned B_TIE    = 0;
  // timer control bit positions
  localparam int unsigned B_RUN    = 7;
endpackage

// File: rtl/cdt_div_stage.sv
module cdt_div_stage #(
  parameter int unsigned DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int unsigned DIV_FAST = 8,
  parameter int unsigned DIV_MID  = 64,
  parameter int unsigned DIV_SEC  = 64,
  parameter int unsigned DIV_MIN  = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_tick_i,
  output logic [3:0] tick_o
);
  localparam int unsigned STAGE_DIV [4] = '{DIV_FAST, DIV_MID, DIV_SEC, DIV_MIN};

  logic [3:0] en_w;

  for (genvar g = 0; g < 4; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign en_w[g] = ref_tick_i;
    end else begin : g_chain
      assign en_w[g] = tick_o[g-1];
    end
    cdt_div_stage #(.DIV(STAGE_DIV[g])) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_w[g]),
      .tick_o (tick_o[g])
    );
  end
endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          src_tick_i,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q, rld_q;
  logic          step;

  assign step     = run_i && src_tick_i && (rld_q != '0) && !load_i;
  assign expire_o = step && (cnt_q <= DW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      rld_q <= load_val_i;
    end else if (step) begin
      cnt_q <= (cnt_q <= DW'(1)) ? rld_q : cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          expire_i,
  input  logic          sec_tick_i,
  input  logic          min_tick_i,
  output logic          run_o,
  output src_e          src_o,
  output logic          tf_o,
  output logic          msf_o,
  output logic          sec_en_o,
  output logic          min_en_o,
  output logic          pulse_mode_o,
  output logic          tval_wr_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic wr_ctrl, wr_tctl;
  logic min_en_q, sec_en_q, msf_q, pulse_q, tf_q, tie_q;
  logic run_q;
  src_e src_q;
  logic msf_evt, tf_evt, irq_pulse_q, irq_level;

  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_tctl   = wr_en_i && (addr_i == ADDR_TCTL);
  assign tval_wr_o = wr_en_i && (addr_i == ADDR_TVAL);

  assign msf_evt = (sec_en_q && sec_tick_i) || (min_en_q && min_tick_i);
  assign tf_evt  = expire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_en_q <= 1'b0;
      sec_en_q <= 1'b0;
      pulse_q  <= 1'b0;
      tie_q    <= 1'b0;
    end else if (wr_ctrl) begin
      min_en_q <= wdata_i[B_MIN_EN];
      sec_en_q <= wdata_i[B_SEC_EN];
      pulse_q  <= wdata_i[B_PULSE];
      tie_q    <= wdata_i[B_TIE];
    end
  end

  // flags: clear by written 0, set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msf_q <= 1'b0;
      tf_q  <= 1'b0;
    end else begin
      if (msf_evt)                        msf_q <= 1'b1;
      else if (wr_ctrl && !wdata_i[B_MSF]) msf_q <= 1'b0;
      if (tf_evt)                         tf_q  <= 1'b1;
      else if (wr_ctrl && !wdata_i[B_TF])  tf_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      src_q <= SRC_MIN;
    end else if (wr_tctl) begin
      run_q <= wdata_i[B_RUN];
      src_q <= src_e'(wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_pulse_q <= 1'b0;
    else         irq_pulse_q <= (tf_evt && tie_q) || msf_evt;
  end

  assign irq_level = (tf_q && tie_q) || (msf_q && (sec_en_q || min_en_q));
  assign irq_o     = pulse_q ? irq_pulse_q : irq_level;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[B_MIN_EN] = min_en_q;
        rdata_o[B_SEC_EN] = sec_en_q;
        rdata_o[B_MSF]    = msf_q;
        rdata_o[B_PULSE]  = pulse_q;
        rdata_o[B_TF]     = tf_q;
        rdata_o[B_TIE]    = tie_q;
      end
      ADDR_TCTL: begin
        rdata_o[B_RUN] = run_q;
        rdata_o[1:0]   = src_q;
      end
      ADDR_TVAL: rdata_o = cnt_i;
      default:   rdata_o = '0;
    endcase
  end

  assign run_o        = run_q;
  assign src_o        = src_q;
  assign tf_o         = tf_q;
  assign msf_o        = msf_q;
  assign sec_en_o     = sec_en_q;
  assign min_en_o     = min_en_q;
  assign pulse_mode_o = pulse_q;
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned DIV_FAST = 8,
  parameter int unsigned DIV_MID  = 64,
  parameter int unsigned DIV_SEC  = 64,
  parameter int unsigned DIV_MIN  = 60
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic [3:0]    tick_w;
  logic          src_tick_w, run_w, expire_w, tval_wr_w;
  logic          tf_w, msf_w, sec_en_w, min_en_w, pulse_mode_w;
  src_e          src_w;
  logic [DW-1:0] cnt_w, rld_w;

  cdt_prescaler #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SEC  (DIV_SEC),
    .DIV_MIN  (DIV_MIN)
  ) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .tick_o     (tick_w)
  );

  always_comb begin
    unique case (src_w)
      SRC_FAST: src_tick_w = tick_w[0];
      SRC_MID:  src_tick_w = tick_w[1];
      SRC_SEC:  src_tick_w = tick_w[2];
      default:  src_tick_w = tick_w[3];
    endcase
  end

  cdt_core u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_w),
    .src_tick_i (src_tick_w),
    .load_i     (tval_wr_w),
    .load_val_i (wdata_i),
    .cnt_o      (cnt_w),
    .rld_o      (rld_w),
    .expire_o   (expire_w)
  );

  cdt_regs u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .cnt_i        (cnt_w),
    .expire_i     (expire_w),
    .sec_tick_i   (tick_w[2]),
    .min_tick_i   (tick_w[3]),
    .run_o        (run_w),
    .src_o        (src_w),
    .tf_o         (tf_w),
    .msf_o        (msf_w),
    .sec_en_o     (sec_en_w),
    .min_en_o     (min_en_w),
    .pulse_mode_o (pulse_mode_w),
    .tval_wr_o    (tval_wr_w),
    .rdata_o      (rdata_o),
    .irq_o        (irq_o)
  );
endmodule

// File: rtl/cdt_timer_checks.sv
module cdt_timer_checks
  import cdt_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          irq_o,
  input logic          run_w,
  input logic          tval_wr_w,
  input logic          expire_w,
  input logic          tf_w,
  input logic          msf_w,
  input logic          sec_en_w,
  input logic          min_en_w,
  input logic          pulse_mode_w,
  input logic [DW-1:0] cnt_w,
  input logic [DW-1:0] rld_w
);
  assert_cnt_within_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= rld_w);

  assert_hold_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !tval_wr_w) |=> $stable(cnt_w));

  assert_zero_no_expiry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rld_w == '0) |-> !expire_w);

  assert_tf_needs_expiry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tf_w) |-> $past(expire_w));

  assert_single_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_mode_w && irq_o) |=> !(pulse_mode_w && irq_o));

  assert_msf_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msf_w) |-> $past(sec_en_w || min_en_w));
endmodule

bind cdt_timer cdt_timer_checks u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .run_w        (run_w),
  .tval_wr_w    (tval_wr_w),
  .expire_w     (expire_w),
  .tf_w         (tf_w),
  .msf_w        (msf_w),
  .sec_en_w     (sec_en_w),
  .min_en_w     (min_en_w),
  .pulse_mode_w (pulse_mode_w),
  .cnt_w        (cnt_w),
  .rld_w        (rld_w)
);

// File: tb/cdt_timer_test.sv
`timescale 1ns/1ps
module cdt_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = 4'h0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // scaled periods: 2, 4, 8, 24 clocks with ref_tick_i held high
  cdt_timer #(.DIV_FAST(2), .DIV_MID(2), .DIV_SEC(2), .DIV_MIN(3)) uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_tick_i (ref_tick_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    rd(a, d);
    check(d == exp, req, d, exp);
  endtask

  // cycles from one irq pulse to the next
  task automatic pulse_gap(output int gap);
    int n;
    gap = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (irq_o) break;
    end
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      n++;
      if (irq_o) begin gap = n; break; end
    end
  endtask

  task automatic t_reset;
    rd_check(4'h1, 8'h00, "R1 control/status");
    rd_check(4'hE, 8'h03, "R1 timer control");
    rd_check(4'hF, 8'h00, "R1 countdown value");
    check(irq_o == 1'b0, "R1 irq", irq_o, 0);
  endtask

  task automatic t_map;
    wr(4'h3, 8'hFF);
    rd_check(4'h3, 8'h00, "R2 unmapped address");
    wr(4'hE, 8'h7C);
    rd_check(4'hE, 8'h00, "R2 timer control pad bits");
    wr(4'h1, 8'h1B);
    rd_check(4'h1, 8'h11, "R2 control/status unused bits");
    wr(4'h1, 8'h00);
    wr(4'hE, 8'h03);
  endtask

  task automatic t_hold;
    wr(4'hF, 8'h05);
    repeat (60) @(negedge clk_i);
    rd_check(4'hF, 8'h05, "R3 count held while stopped");
    wr(4'hE, 8'h80);
    repeat (12) @(negedge clk_i);
    begin
      logic [7:0] d;
      rd(4'hF, d);
      check(d != 8'h05 && d >= 8'h01, "R3 count moves once running", d, 5);
    end
    wr(4'hE, 8'h00);
  endtask

  task automatic t_period(input logic [1:0] src, input logic [7:0] val, input int exp, input string req);
    int gap;
    wr(4'hE, 8'h03);
    wr(4'h1, 8'h11);              // pulse mode, timer irq enable
    wr(4'hF, val);
    wr(4'hE, {6'b100000, src});
    pulse_gap(gap);
    check(gap == exp, req, gap, exp);
    wr(4'hE, 8'h03);
  endtask

  task automatic t_zero;
    int hits = 0;
    wr(4'h1, 8'h01);              // level mode, TIE, clears TF
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h80);
    for (int i = 0; i < 80; i++) begin
      @(negedge clk_i);
      if (irq_o) hits++;
    end
    check(hits == 0, "R6 zero reload gives no irq", hits, 0);
    rd_check(4'h1, 8'h01, "R6 timer flag stays clear");
    wr(4'hE, 8'h00);
  endtask

  task automatic t_level;
    bit seen = 0;
    wr(4'h1, 8'h01);
    wr(4'hF, 8'h02);
    wr(4'hE, 8'h80);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (irq_o) begin seen = 1; break; end
    end
    check(seen, "R8 level irq on TF and TIE", seen, 1);
    wr(4'hE, 8'h00);
    rd_check(4'h1, 8'h05, "R7 expiry sets timer flag");
    wr(4'h1, 8'h04);
    check(irq_o == 1'b0, "R8 TIE low masks irq", irq_o, 0);
    rd_check(4'h1, 8'h04, "R7 writing 1 keeps flag");
    wr(4'h1, 8'h05);
    check(irq_o == 1'b1, "R8 TIE high shows flag", irq_o, 1);
    wr(4'h1, 8'h01);
    check(irq_o == 1'b0, "R7 written 0 clears flag", irq_o, 0);
    wr(4'h1, 8'h05);
    rd_check(4'h1, 8'h01, "R7 writing 1 cannot set flag");
    wr(4'h1, 8'h00);
  endtask

  task automatic t_secmin;
    bit seen = 0;
    int gap;
    int hits = 0;
    wr(4'h1, 8'h40);               // second enable, level
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (irq_o) begin seen = 1; break; end
    end
    check(seen, "R10 second event sets flag / R8 irq", seen, 1);
    begin
      logic [7:0] d;
      rd(4'h1, d);
      check(d[5] == 1'b1, "R10 flag bit 5 set", d, 8'h60);
    end
    wr(4'h1, 8'h00);
    rd_check(4'h1, 8'h00, "R10 written 0 clears flag");
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (irq_o) hits++;
    end
    rd_check(4'h1, 8'h00, "R10 no set with enables off");
    check(hits == 0, "R10 no irq with enables off", hits, 0);
    wr(4'h1, 8'h50);               // second enable, pulse mode
    pulse_gap(gap);
    check(gap == 8, "R9 second pulse spacing", gap, 8);
    wr(4'h1, 8'h90);               // minute enable, pulse mode
    pulse_gap(gap);
    check(gap == 24, "R10 minute pulse spacing", gap, 24);
    wr(4'h1, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    ref_tick_i = 1'b1;
    t_reset();
    t_map();
    t_hold();
    t_period(2'b00, 8'd3, 6,  "R4 R5 source 00 N=3");
    t_period(2'b01, 8'd2, 8,  "R4 R5 source 01 N=2");
    t_period(2'b10, 8'd2, 16, "R4 R5 source 10 N=2");
    t_period(2'b11, 8'd1, 24, "R4 R5 source 11 N=1");
    t_period(2'b00, 8'd1, 2,  "R9 pulse per expiry N=1");
    t_zero();
    t_level();
    t_secmin();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule